// File: doc/BRIEF.md
# Asynchronous HDLC Receive Deframer

This block sits behind a byte-oriented serial receiver and rebuilds HDLC frames from the character stream. It looks for the 0x7E delimiter and undoes the 0x7D escape, which XORs the next byte with 0x20. It drops idle characters and any control characters that are selected in a 32-bit map. Each recovered byte comes out one cycle after it is accepted. When a frame closes, the block sends a one-cycle end beat that carries a status code.

A frame can end in four ways: a closing flag, an abort, loss of carrier, or growing past a programmable length limit. A closing flag gives a good or CRC-error status, based on the CRC-16/CCITT residue over the data and both check bytes. After an abort, carrier loss or length overrun, the block ignores everything up to the next flag.

Top module: `hdlc_async_rx_deframer`

## Requirements
- R1: Bytes accepted between an opening and a closing 0x7E come out on `out_valid`/`out_data` in order, one cycle after acceptance. `out_sof` marks the first byte of the frame. The closing flag raises `out_end` one cycle after it is accepted.
- R2: An unconsumed 0x7D is never output. The next data byte is output XORed with 0x20, whatever value results, including 0x7E and 0x7D.
- R3: A 0xFF byte is ignored in every state and leaves a pending escape pending.
- R4: A raw byte below 0x20 whose bit in `ctrl_map` is set (bit index = byte value) is discarded and leaves a pending escape pending. If its bit is clear, the byte is received normally.
- R5: On a closing flag, status is 0 (`out_good` high) when the CRC-16/CCITT (reflected polynomial 0x8408, initial value 0xFFFF) over all frame bytes, including the two check bytes, equals 0xF0B8. Otherwise status is 1.
- R6: Back-to-back flags with no data between them produce no output.
- R7: 0x7D directly followed by 0x7E ends a frame that holds data with status 2. Bytes are then ignored until the next 0x7E, which opens a new frame.
- R8: While `carrier_ok` is low, input is ignored. If a frame holding data is open, it ends with status 3 one cycle after carrier is first seen low. The block then waits for a flag.
- R9: A data byte that would make the frame longer than `max_len` (check bytes included) is not output. The frame ends with status 4, and the block waits for a flag.
- R10: After reset all outputs are low and the block waits for a flag. Bytes before the first flag produce no output.
- R11: `out_valid` and `out_end` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received character strobe |
| in_byte | input | 8 | Received character |
| carrier_ok | input | 1 | Carrier present |
| ctrl_map | input | 32 | Discard mask for characters 0x00..0x1F |
| max_len | input | LEN_W | Largest frame length in bytes, check bytes included |
| out_valid | output | 1 | Data byte beat |
| out_data | output | 8 | Recovered data byte |
| out_sof | output | 1 | First byte of frame |
| out_end | output | 1 | Frame end beat |
| out_status | output | 3 | End status: 0 good, 1 CRC, 2 abort, 3 carrier, 4 length |
| out_good | output | 1 | End beat with status 0 |

## Verification
Every output depends on the byte accepted one cycle earlier, so an error in the escape, open or length state shows up at the next data byte. A wrong data value, a missing or extra beat, or a misplaced `out_sof` is visible within one cycle. A corrupted running CRC stays hidden until the closing flag, where it appears as the wrong end status. The bench therefore closes every frame and compares each cycle against a queue-based model.

// File: rtl/hdlc_async_rx_deframer.sv
`timescale 1ns/1ps
module hdlc_async_rx_deframer #(
  parameter int          LEN_W    = 12,
  parameter logic [15:0] CRC_GOOD = 16'hF0B8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             carrier_ok,
  input  logic [31:0]      ctrl_map,
  input  logic [LEN_W-1:0] max_len,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_end,
  output logic [2:0]       out_status,
  output logic             out_good
);
  localparam logic [7:0] FLAG = 8'h7E;
  localparam logic [7:0] ESC  = 8'h7D;
  localparam logic [7:0] IDLE = 8'hFF;
  localparam logic [7:0] XORV = 8'h20;
  localparam logic [2:0] ST_OK = 3'd0, ST_CRC = 3'd1, ST_ABORT = 3'd2,
                         ST_CARRIER = 3'd3, ST_LENGTH = 3'd4;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  logic             open_q, esc_q;
  logic [LEN_W-1:0] len_q;
  logic [15:0]      crc_q;

  wire       mapped   = (in_byte[7:5] == 3'b000) && ctrl_map[in_byte[4:0]];
  wire       take     = in_valid && (in_byte != IDLE) && !mapped;
  wire       is_flag  = in_byte == FLAG;
  wire       is_esc   = (in_byte == ESC) && !esc_q;
  wire [7:0] restored = esc_q ? (in_byte ^ XORV) : in_byte;
  wire       has_data = len_q != '0;
  wire       over     = len_q == max_len;

  assign out_good = out_end && (out_status == ST_OK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      esc_q      <= 1'b0;
      len_q      <= '0;
      crc_q      <= 16'hFFFF;
      out_valid  <= 1'b0;
      out_data   <= 8'h00;
      out_sof    <= 1'b0;
      out_end    <= 1'b0;
      out_status <= ST_OK;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_end   <= 1'b0;
      if (!carrier_ok) begin
        if (open_q && has_data) begin
          out_end    <= 1'b1;
          out_status <= ST_CARRIER;
        end
        open_q <= 1'b0;
        esc_q  <= 1'b0;
      end else if (take) begin
        if (is_flag) begin
          if (open_q && has_data) begin
            out_end    <= 1'b1;
            out_status <= esc_q ? ST_ABORT : ((crc_q == CRC_GOOD) ? ST_OK : ST_CRC);
          end
          open_q <= !(open_q && esc_q);
          esc_q  <= 1'b0;
          len_q  <= '0;
          crc_q  <= 16'hFFFF;
        end else if (open_q) begin
          if (is_esc) begin
            esc_q <= 1'b1;
          end else begin
            esc_q <= 1'b0;
            if (over) begin
              out_end    <= 1'b1;
              out_status <= ST_LENGTH;
              open_q     <= 1'b0;
            end else begin
              out_valid <= 1'b1;
              out_data  <= restored;
              out_sof   <= !has_data;
              len_q     <= len_q + 1'b1;
              crc_q     <= crc_step(crc_q, restored);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_async_rx_deframer_chk.sv
`timescale 1ns/1ps
module hdlc_async_rx_deframer_chk #(
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [7:0]       in_byte,
  input logic             carrier_ok,
  input logic [31:0]      ctrl_map,
  input logic [LEN_W-1:0] max_len,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_end,
  input logic [2:0]       out_status
);
  logic [LEN_W:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (out_valid) seen <= out_sof ? {{LEN_W{1'b0}}, 1'b1} : seen + 1'b1;
  end

  AST_BEAT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_end)); // R11
  AST_SOF_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid); // R1
  AST_DATA_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid) && $past(carrier_ok))); // R1
  AST_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_end |-> ($past(in_valid) || !$past(carrier_ok))); // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_byte == 8'hFF && carrier_ok) |=> (!out_valid && !out_end)); // R3
  AST_MAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && carrier_ok && in_byte[7:5] == 3'b000 && ctrl_map[in_byte[4:0]])
      |=> (!out_valid && !out_end)); // R4
  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof) |-> (seen < {1'b0, max_len})); // R9
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_end |-> (out_status <= 3'd4)); // R5
endmodule

bind hdlc_async_rx_deframer hdlc_async_rx_deframer_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
  .carrier_ok(carrier_ok), .ctrl_map(ctrl_map), .max_len(max_len),
  .out_valid(out_valid), .out_sof(out_sof), .out_end(out_end),
  .out_status(out_status));

// File: tb/test_hdlc_async_rx_deframer.sv
`timescale 1ns/1ps
module test_hdlc_async_rx_deframer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        carrier_ok = 1'b1;
  logic [31:0] tb_map = 32'h0;
  logic [11:0] tb_max = 12'd100;
  logic        out_valid, out_sof, out_end, out_good;
  logic [7:0]  out_data;
  logic [2:0]  out_status;

  int    n_run = 0, n_fail = 0;
  string cur = "R10";

  always #5 clk = ~clk;

  hdlc_async_rx_deframer #(.LEN_W(12)) i_hdlc_async_rx_deframer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .carrier_ok(carrier_ok), .ctrl_map(tb_map), .max_len(tb_max),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_end(out_end), .out_status(out_status), .out_good(out_good));

  bit          m_open = 0, m_esc = 0;
  int          m_len = 0;
  logic [7:0]  fq[$];
  int          ek, es, ed, esof;

  function automatic int crc_of(logic [7:0] q[$]);
    int c = 16'hFFFF;
    foreach (q[i]) begin
      for (int k = 0; k < 8; k++) begin
        int fb = (c ^ (q[i] >> k)) & 1;
        c = c >> 1;
        if (fb != 0) c = c ^ 16'h8408;
      end
    end
    return c;
  endfunction

  task automatic model(input bit v, input logic [7:0] b, input bit cd);
    ek = 0;
    if (!cd) begin
      if (m_open && m_len > 0) begin ek = 2; es = 3; end
      m_open = 0; m_esc = 0;
    end else if (v && b != 8'hFF && !(b < 8'h20 && tb_map[b[4:0]])) begin
      if (b == 8'h7E) begin
        if (m_open && m_len > 0) begin
          ek = 2;
          es = m_esc ? 2 : ((crc_of(fq) == 16'hF0B8) ? 0 : 1);
        end
        m_open = !(m_open && m_esc); m_esc = 0; m_len = 0; fq.delete();
      end else if (m_open) begin
        if (b == 8'h7D && !m_esc) m_esc = 1;
        else begin
          logic [7:0] d;
          d = m_esc ? (b ^ 8'h20) : b;
          m_esc = 0;
          if (m_len >= int'(tb_max)) begin ek = 2; es = 4; m_open = 0; end
          else begin ek = 1; ed = d; esof = (m_len == 0); m_len++; fq.push_back(d); end
        end
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [7:0] b, input bit cd);
    in_valid = v; in_byte = b; carrier_ok = cd;
    model(v, b, cd);
    @(negedge clk);
    check(out_valid == (ek == 1), cur, "out_valid", out_valid, ek == 1);
    check(out_end == (ek == 2), cur, "out_end", out_end, ek == 2);
    check(!(out_valid && out_end), "R11", "valid with end", 1, 0);
    if (ek == 1) begin
      check(out_data == ed[7:0], cur, "out_data", out_data, ed);
      check(out_sof == esof[0], cur, "out_sof", out_sof, esof);
    end
    if (ek == 2) begin
      check(out_status == es[2:0], cur, "out_status", out_status, es);
      check(out_good == (es == 0), cur, "out_good", out_good, es == 0);
    end
  endtask

  task automatic sb(input logic [7:0] b); step(1'b1, b, 1'b1); endtask

  task automatic sesc(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D || b < 8'h20) begin sb(8'h7D); sb(b ^ 8'h20); end
    else sb(b);
  endtask

  task automatic frame(input logic [7:0] p[$], input bit corrupt);
    int f;
    f = crc_of(p) ^ 16'hFFFF;
    if (corrupt) f = f ^ 16'h0001;
    sb(8'h7E);
    foreach (p[i]) sesc(p[i]);
    sesc(f[7:0]);
    sesc(f[15:8]);
    sb(8'h7E);
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    check(!out_valid && !out_end && !out_sof && !out_good, "R10", "outputs in reset",
          {out_valid, out_end, out_sof, out_good}, 0);
    rst_n = 1'b1;
    cur = "R10"; sb(8'h41); sb(8'h42); step(0, 8'h00, 1);

    cur = "R1";  frame('{8'h48, 8'h69, 8'h21, 8'h30}, 0);
    cur = "R2";  frame('{8'h7E, 8'h7D, 8'h03, 8'h5A}, 0);
    sb(8'h7E); sb(8'h7D); sb(8'h5E); sb(8'h7D); sb(8'h7D); sb(8'h7E);
    cur = "R5";  frame('{8'h10, 8'h20, 8'h30}, 1);
    frame('{8'hA5}, 0);
    cur = "R6";  sb(8'h7E); sb(8'h7E); step(0, 8'h00, 1); sb(8'h7E);
    cur = "R3";  sb(8'h7E); sb(8'h41); sb(8'hFF); sb(8'h7D); sb(8'hFF); sb(8'h5E); sb(8'hFF); sb(8'h7E);
    sb(8'hFF); sb(8'hFF);
    cur = "R4";  tb_map = (32'h1 << 8'h11) | (32'h1 << 8'h13);
    sb(8'h7E); sb(8'h41); sb(8'h11); sb(8'h05); sb(8'h13); sb(8'h7D); sb(8'h11); sb(8'h31); sb(8'h7E);
    tb_map = 32'h0;
    cur = "R7";  sb(8'h7E); sb(8'h41); sb(8'h42); sb(8'h7D); sb(8'h7E);
    sb(8'h43); sb(8'h44); sb(8'h7E); sb(8'h45); sb(8'h7E);
    sb(8'h7D); sb(8'h7E); sb(8'h46); sb(8'h7E);
    cur = "R8";  sb(8'h7E); sb(8'h41); sb(8'h42);
    step(1, 8'h43, 0); step(0, 8'h00, 0); step(1, 8'h7E, 0);
    sb(8'h44); frame('{8'h01, 8'h02}, 0);
    cur = "R9";  tb_max = 12'd6;
    frame('{8'h11, 8'h22, 8'h33, 8'h44}, 0);
    frame('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, 0);
    sb(8'h66); sb(8'h7E);
    tb_max = 12'd100;
    cur = "R11"; frame('{8'h55, 8'hAA, 8'h7E}, 0); frame('{8'h00, 8'hFE}, 0);
    repeat (3) step(0, 8'h00, 1);
    report();
  end
endmodule